// File: doc/BRIEF.md
# LIN Slave Header Receiver

This block listens to a LIN bus on behalf of a slave node and picks out the frame header. It recognises a break as a dominant run far longer than any legal character. It then takes the sync character and checks it against the expected 0x55 pattern. Finally it captures the protected identifier character and reports it through a status flag. The flag can raise an interrupt request when a mask bit allows it.

The receive line is sampled only on cycles where an oversampling enable is high. Each bit spans a fixed number of enable ticks, and the block samples in the middle of the bit. The sync character is only validated, not measured, so the nominal bit rate stays in use. A reset-status command clears the flag. An optional parity check compares the two top identifier bits with the LIN protected-identifier equations.

Top module: `lin_hdr_rx`

## Requirements
- R1: A break is recognised only after 11 consecutive bit times of dominant (0) level, that is 176 consecutive ticks at the default 16 ticks per bit. Any recessive tick sample restarts the count. A dominant run of 10 bit times is not a break, and the header that follows it is ignored.
- R2: After a break, the block waits for a recessive level and then receives the sync character. The character is framed as a start bit of 0, eight data bits sent LSB first, and a stop bit of 1. Each bit is sampled at mid-bit. If the sync data is not 0x55 or its stop bit is 0, header reception is abandoned: `hdr_id` keeps its old value and `id_valid` stays clear.
- R3: The character after a valid sync is the identifier. If its stop bit is 1, `hdr_id` takes the received byte and `id_valid` is set, one clock after the stop-bit sample. If its stop bit is 0, nothing is stored and the flag is not set.
- R4: With `par_chk_en` high, an identifier is flagged by `par_err` when bit 6 differs from id0^id1^id2^id4 or bit 7 differs from the inverse of id1^id3^id4^id5. The identifier is stored either way. With `par_chk_en` low, `par_err` stays 0 after a capture.
- R5: `irq` is high exactly when `id_valid` is high and `irq_en` is high.
- R6: A one on `sts_clr` for one cycle clears `id_valid` and `par_err` on the next clock edge. A capture in the same cycle takes precedence.
- R7: After the identifier's stop bit, the block waits for a recessive level before it looks for a break again. A valid header that follows immediately after an earlier one, with an exactly 11-bit break, is still accepted.
- R8: After reset `hdr_id` is 0x00 and `id_valid`, `par_err` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Oversampling enable, one tick per 1/16 bit |
| rxd | input | 1 | Serial receive line, 0 = dominant |
| par_chk_en | input | 1 | Enables identifier parity checking |
| irq_en | input | 1 | Interrupt mask bit for the identifier flag |
| sts_clr | input | 1 | Reset-status command, clears the flags |
| hdr_id | output | 8 | Last identifier captured |
| id_valid | output | 1 | Identifier-received status flag |
| par_err | output | 1 | Parity mismatch on the last identifier |
| irq | output | 1 | Interrupt request |

## Verification
Headers are sent on a bus with oversampling ticks on every other clock. The set of headers covers several cases:
- Clean headers with 13-bit and exactly 11-bit breaks, which show that the break threshold and the re-arming after a header both work.
- A 10-bit break, which shows that a short dominant run is not taken as a break.
- A wrong sync value and a sync character with its stop bit forced to 0, which exercise the two abort paths of the sync stage.
- An identifier with a missing stop bit, which separates a framing failure from a capture.
- Identifiers with correct and with corrupted parity bits, with checking switched on and off, which show that the error flag depends on both the check enable and the parity bits.

The mask and reset-status inputs are toggled around a captured header to show their effect on the interrupt line.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

    localparam int CHAR_W = 8;
    localparam logic [CHAR_W-1:0] SYNC_CHAR = 8'h55;

    typedef enum logic [2:0] {
        ST_BRK    = 3'd0,
        ST_DELIM  = 3'd1,
        ST_WSTART = 3'd2,
        ST_CHAR   = 3'd3,
        ST_WREC   = 3'd4
    } hdr_st_e;

endpackage

// File: rtl/lin_brk_det.sv
module lin_brk_det #(
    parameter int OVS      = 16,
    parameter int BRK_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic tick,
    input  logic rxd,
    output logic hit
);
    localparam int BT = OVS * BRK_BITS;
    localparam int BW = $clog2(BT + 1);
    localparam logic [BW-1:0] LAST = BW'(BT - 1);

    logic [BW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!arm) begin
            cnt_d = '0;
        end else if (tick) begin
            if (rxd)
                cnt_d = '0;
            else if (cnt_q != LAST)
                cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // fires on the BT-th consecutive dominant tick
    assign hit = arm && tick && !rxd && (cnt_q == LAST);
endmodule

// File: rtl/lin_id_check.sv
module lin_id_check
    import lin_hdr_pkg::*;
(
    input  logic [CHAR_W-1:0] id_char,
    output logic              mismatch
);
    logic p_lo, p_hi;

    always_comb begin
        p_lo     = id_char[0] ^ id_char[1] ^ id_char[2] ^ id_char[4];
        p_hi     = ~(id_char[1] ^ id_char[3] ^ id_char[4] ^ id_char[5]);
        mismatch = (id_char[6] != p_lo) || (id_char[7] != p_hi);
    end
endmodule

// File: rtl/lin_hdr_rx.sv
module lin_hdr_rx
    import lin_hdr_pkg::*;
#(
    parameter int OVS      = 16,
    parameter int BRK_BITS = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic              par_chk_en,
    input  logic              irq_en,
    input  logic              sts_clr,
    output logic [CHAR_W-1:0] hdr_id,
    output logic              id_valid,
    output logic              par_err,
    output logic              irq
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(CHAR_W + 2);
    localparam logic [CNT_W-1:0] HALF_M1   = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_M1   = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] LAST_DATA = IDX_W'(CHAR_W);

    typedef struct packed {
        hdr_st_e           st;
        logic              ph_id;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [CHAR_W-1:0] shift;
        logic [CHAR_W-1:0] id;
        logic              flag;
        logic              perr;
    } rx_state_t;

    rx_state_t d, q;
    logic      brk_hit;
    logic      par_bad;
    logic      id_cap;

    lin_brk_det #(.OVS(OVS), .BRK_BITS(BRK_BITS)) u_brk (
        .clk  (clk),
        .rst_n(rst_n),
        .arm  (q.st == ST_BRK),
        .tick (os_tick),
        .rxd  (rxd),
        .hit  (brk_hit)
    );

    lin_id_check u_par (
        .id_char (q.shift),
        .mismatch(par_bad)
    );

    always_comb begin
        d      = q;
        id_cap = 1'b0;
        if (sts_clr) begin
            d.flag = 1'b0;
            d.perr = 1'b0;
        end
        if (os_tick) begin
            unique case (q.st)
                ST_BRK: begin
                    if (brk_hit) begin
                        d.st    = ST_DELIM;
                        d.ph_id = 1'b0;
                    end
                end
                ST_DELIM: begin
                    if (rxd) d.st = ST_WSTART;
                end
                ST_WSTART: begin
                    if (!rxd) begin
                        d.st  = ST_CHAR;
                        d.cnt = HALF_M1;
                        d.idx = '0;
                    end
                end
                ST_CHAR: begin
                    if (q.cnt != '0) begin
                        d.cnt = q.cnt - 1'b1;
                    end else begin
                        d.cnt = FULL_M1;
                        d.idx = q.idx + 1'b1;
                        if (q.idx == '0) begin
                            if (rxd) d.st = ST_BRK;     // false start
                        end else if (q.idx <= LAST_DATA) begin
                            d.shift = {rxd, q.shift[CHAR_W-1:1]};
                        end else if (!rxd) begin
                            d.st = ST_BRK;              // framing error
                        end else if (!q.ph_id) begin
                            if (q.shift == SYNC_CHAR) begin
                                d.st    = ST_WSTART;
                                d.ph_id = 1'b1;
                            end else begin
                                d.st = ST_BRK;
                            end
                        end else begin
                            id_cap = 1'b1;
                            d.id   = q.shift;
                            d.flag = 1'b1;
                            d.perr = par_chk_en && par_bad;
                            d.st   = ST_WREC;
                        end
                    end
                end
                ST_WREC: begin
                    if (rxd) d.st = ST_BRK;
                end
                default: d.st = ST_BRK;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_BRK;
        end else begin
            q <= d;
        end
    end

    assign hdr_id   = q.id;
    assign id_valid = q.flag;
    assign par_err  = q.perr;
    assign irq      = q.flag && irq_en;
endmodule

// File: rtl/lin_hdr_rx_chk.sv
module lin_hdr_rx_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cap,
    input logic         par_chk_en,
    input logic         irq_en,
    input logic         sts_clr,
    input logic [W-1:0] hdr_id,
    input logic         id_valid,
    input logic         par_err,
    input logic         irq
);
    a_r3_id_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(hdr_id));

    a_r3_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> id_valid);

    a_r4_perr_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && !par_chk_en) |=> !par_err);

    a_r5_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    a_r5_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && irq_en) |-> irq);

    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_clr && !cap) |=> (!id_valid && !par_err));

    a_r6_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_valid) |-> $past(cap));
endmodule

bind lin_hdr_rx lin_hdr_rx_chk #(.W(lin_hdr_pkg::CHAR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap       (id_cap),
    .par_chk_en(par_chk_en),
    .irq_en    (irq_en),
    .sts_clr   (sts_clr),
    .hdr_id    (hdr_id),
    .id_valid  (id_valid),
    .par_err   (par_err),
    .irq       (irq)
);

// File: tb/test_lin_hdr_rx.sv
module test_lin_hdr_rx;
    localparam int CLK_PERIOD = 10;
    localparam int OVS        = 16;
    localparam int BIT_CLKS   = 2 * OVS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       par_chk_en = 1'b0;
    logic       irq_en = 1'b0;
    logic       sts_clr = 1'b0;
    logic [7:0] hdr_id;
    logic       id_valid, par_err, irq;

    int checks = 0;
    int fails  = 0;
    logic [7:0] last_id = 8'h00;

    typedef struct {
        string      tag;
        logic       flag;
        logic [7:0] id;
        logic       perr;
    } exp_t;
    exp_t exp_q[$];

    lin_hdr_rx i_lin_hdr_rx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .par_chk_en(par_chk_en), .irq_en(irq_en), .sts_clr(sts_clr),
        .hdr_id(hdr_id), .id_valid(id_valid), .par_err(par_err), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            os_tick = ~os_tick;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic perr_of(input logic [7:0] id, input logic en);
        logic p0, p1;
        p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
        p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return en && ((id[6] != p0) || (id[7] != p1));
    endfunction

    task automatic send_bit(input logic b);
        rxd = b;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] c, input logic stop);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(c[i]);
        send_bit(stop);
    endtask

    // driver: clears status, sends a header, pushes the expected outcome
    task automatic frame(input string tag, input int brk, input logic [7:0] sync,
                         input logic sstop, input logic [7:0] id, input logic istop);
        logic ok;
        exp_t e;
        sts_clr = 1'b1;
        @(negedge clk);
        sts_clr = 1'b0;
        for (int i = 0; i < brk; i++) send_bit(1'b0);
        send_bit(1'b1);
        send_char(sync, sstop);
        send_char(id, istop);
        send_bit(1'b1);
        send_bit(1'b1);
        ok = (brk >= 11) && (sync == 8'h55) && sstop && istop;
        if (ok) last_id = id;
        e.tag  = tag;
        e.flag = ok;
        e.id   = last_id;
        e.perr = ok && perr_of(id, par_chk_en);
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    // monitor: pops expectations and compares against the outputs
    initial begin
        forever begin
            exp_t e;
            wait (exp_q.size() != 0);
            e = exp_q.pop_front();
            chk({e.tag, " id_valid"}, {7'd0, id_valid}, {7'd0, e.flag});
            chk({e.tag, " hdr_id"}, hdr_id, e.id);
            chk({e.tag, " par_err"}, {7'd0, par_err}, {7'd0, e.perr});
            chk({e.tag, " irq (R5)"}, {7'd0, irq}, {7'd0, e.flag && irq_en});
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset hdr_id", hdr_id, 8'h00);
        chk("R8 reset id_valid", {7'd0, id_valid}, 8'h00);
        chk("R8 reset par_err", {7'd0, par_err}, 8'h00);
        chk("R8 reset irq", {7'd0, irq}, 8'h00);
        repeat (3) send_bit(1'b1);

        frame("R3 valid 13-bit break", 13, 8'h55, 1'b1, 8'h12, 1'b1);

        irq_en = 1'b1;
        @(negedge clk);
        chk("R5 irq with mask", {7'd0, irq}, 8'h01);
        sts_clr = 1'b1;
        @(negedge clk);
        sts_clr = 1'b0;
        @(negedge clk);
        chk("R6 clear id_valid", {7'd0, id_valid}, 8'h00);
        chk("R6 irq after clear", {7'd0, irq}, 8'h00);
        chk("R6 hdr_id kept", hdr_id, 8'h12);

        frame("R1 10-bit break ignored", 10, 8'h55, 1'b1, 8'h21, 1'b1);
        frame("R2 bad sync", 13, 8'h54, 1'b1, 8'h21, 1'b1);
        frame("R2 sync stop missing", 13, 8'h55, 1'b0, 8'h21, 1'b1);
        frame("R3 id stop missing", 13, 8'h55, 1'b1, 8'h21, 1'b0);
        irq_en = 1'b0;
        frame("R4 check off, bad parity", 13, 8'h55, 1'b1, 8'hBC, 1'b1);
        par_chk_en = 1'b1;
        frame("R4 good parity", 13, 8'h55, 1'b1, 8'h3C, 1'b1);
        frame("R4 bad parity", 13, 8'h55, 1'b1, 8'hBC, 1'b1);
        chk("R4 bad parity flagged", {7'd0, par_err}, 8'h01);
        irq_en = 1'b1;
        frame("R7 exact 11-bit break", 11, 8'h55, 1'b1, 8'h97, 1'b1);
        frame("R7 back-to-back header", 11, 8'h55, 1'b1, 8'h64, 1'b1);

        wait (exp_q.size() == 0);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule